// File: doc/BRIEF.md
# Strap-Latched Frequency Select Controller

This block takes a one-time snapshot of two board strap inputs when the platform's active-low power-good strobe first goes low. From then on it holds that snapshot and turns it into a mode code and a CPU frequency index for the rest of the clock logic. Before the snapshot is taken, the mode code reports "not locked", so downstream clocks can stay quiet.

The B strap is a three-level pin, and an external level detector presents it as a 2-bit code. If B is at mid level when the snapshot is taken, the block enters a test mode that cannot be left except by a reset. In that mode, the live A strap chooses, with no clock involved, between all outputs at high impedance and all outputs running from a divided reference. A live boost input stands for a configuration register bit. When boost is set, the normal-mode frequencies double. The captured strap bits are also brought out so that a register file can read them back.

Top module: `fsel_strap_ctrl`

## Requirements
- R1: After reset, and until a capture occurs, `mode_o` is 0 (not locked), `freq_idx_o` is 7 (none) and `strap_rb_o` is 00.
- R2: The strobe passes through a two-flop synchronizer. When `pgood_n` is low before rising edge 1, the capture happens at edge 3 and the outputs change after edge 3, not before.
- R3: Once a capture has occurred, later changes on `pgood_n`, `strap_a` or `strap_b` do not change `freq_idx_o` or `strap_rb_o` in normal mode.
- R4: In normal mode `mode_o` is 1. With boost clear, the captured A,B pair decodes as follows: 00 gives index 0 (100 MHz), 01 gives index 2 (200 MHz), 10 gives index 1 (133 MHz), and the unlisted pair 11 gives index 0.
- R5: With `boost_sel` set, and applied live, the same pairs give different indices: 00 gives index 2 (200 MHz), 01 gives index 4 (400 MHz), 10 gives index 3 (266 MHz), and 11 gives index 2.
- R6: `strap_b` is coded 00 = low, 01 = high, and 10 or 11 = mid. If B is mid at capture, the block enters test mode, which is sticky. After that, B is ignored.
- R7: In test mode the live `strap_a` drives the mode with no clock edge needed. 0 gives `mode_o` = 2 (divided reference) and 1 gives `mode_o` = 3 (high impedance). In both cases `freq_idx_o` is 7.
- R8: `strap_rb_o` bit 0 holds the captured A and bit 1 holds the captured B (high = 1). A mid-level B reads back as 0.
- R9: Reset is the only way out of test mode. A new capture with B high or low after reset gives normal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset (power cycle) |
| pgood_n | input | 1 | Active-low power-good strobe, asynchronous |
| strap_a | input | 1 | A frequency strap |
| strap_b | input | 2 | B strap level code: 00 low, 01 high, 1x mid |
| boost_sel | input | 1 | Register override selecting doubled frequencies |
| mode_o | output | 2 | 0 not locked, 1 normal, 2 test reference/N, 3 test high-Z |
| freq_idx_o | output | 3 | CPU frequency index: 0=100, 1=133, 2=200, 3=266, 4=400, 7=none |
| strap_rb_o | output | 2 | Captured straps for readback: bit 1 = B, bit 0 = A |

## Verification
The hardest behaviour to reach is the asynchronous test-mode selection. It needs a mid-level B at the exact capture edge, and then a change on A that must show up with no clock edge at all. The stimulus takes care of this in three steps. It holds B at a mid code across the three synchronizer edges. It then changes A in the middle of a clock phase and samples one nanosecond later. Finally, it drives B back to a legal level and clocks for several cycles to show that test mode stays.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

  localparam int MODE_W = 2;
  localparam int FIDX_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_UNLOCKED = 2'd0,
    MODE_RUN      = 2'd1,
    MODE_TEST_REF = 2'd2,
    MODE_TEST_HIZ = 2'd3
  } fsel_mode_e;

  localparam logic [FIDX_W-1:0] FIDX_100  = 3'd0;
  localparam logic [FIDX_W-1:0] FIDX_133  = 3'd1;
  localparam logic [FIDX_W-1:0] FIDX_200  = 3'd2;
  localparam logic [FIDX_W-1:0] FIDX_266  = 3'd3;
  localparam logic [FIDX_W-1:0] FIDX_400  = 3'd4;
  localparam logic [FIDX_W-1:0] FIDX_NONE = 3'd7;

  // Three-level strap code: bit 1 set means mid level.
  function automatic logic strap_is_mid(input logic [1:0] lvl);
    return lvl[1];
  endfunction

  // Binary value of a two-level strap; mid collapses to 0.
  function automatic logic strap_bit(input logic [1:0] lvl);
    return lvl[1] ? 1'b0 : lvl[0];
  endfunction

  // CPU frequency index from captured straps and boost override.
  function automatic logic [FIDX_W-1:0] cpu_freq_idx(input logic a, input logic b,
                                                    input logic boost);
    logic [FIDX_W-1:0] idx;
    unique case ({a, b})
      2'b01:   idx = boost ? FIDX_400 : FIDX_200;
      2'b10:   idx = boost ? FIDX_266 : FIDX_133;
      default: idx = boost ? FIDX_200 : FIDX_100;
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/fsel_sync.sv
module fsel_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fsel_capture.sv
module fsel_capture
  import fsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pg_sync_n,
  input  logic       strap_a,
  input  logic [1:0] strap_b,
  output logic       locked,
  output logic       test_mode,
  output logic       cap_a,
  output logic       cap_b,
  output logic       cap_evt
);
  // One-shot: fires only while still unlocked.
  assign cap_evt = !locked && !pg_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      test_mode <= 1'b0;
      cap_a     <= 1'b0;
      cap_b     <= 1'b0;
    end else if (cap_evt) begin
      locked    <= 1'b1;
      test_mode <= strap_is_mid(strap_b);
      cap_a     <= strap_a;
      cap_b     <= strap_bit(strap_b);
    end
  end
endmodule

// File: rtl/fsel_decode.sv
module fsel_decode
  import fsel_pkg::*;
(
  input  logic              locked,
  input  logic              test_mode,
  input  logic              cap_a,
  input  logic              cap_b,
  input  logic              live_a,
  input  logic              boost,
  output fsel_mode_e        mode,
  output logic [FIDX_W-1:0] freq_idx
);
  always_comb begin
    if (!locked) begin
      mode     = MODE_UNLOCKED;
      freq_idx = FIDX_NONE;
    end else if (test_mode) begin
      // live strap, no register on this path
      mode     = live_a ? MODE_TEST_HIZ : MODE_TEST_REF;
      freq_idx = FIDX_NONE;
    end else begin
      mode     = MODE_RUN;
      freq_idx = cpu_freq_idx(cap_a, cap_b, boost);
    end
  end
endmodule

// File: rtl/fsel_strap_ctrl.sv
module fsel_strap_ctrl
  import fsel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgood_n,
  input  logic              strap_a,
  input  logic [1:0]        strap_b,
  input  logic              boost_sel,
  output logic [MODE_W-1:0] mode_o,
  output logic [FIDX_W-1:0] freq_idx_o,
  output logic [1:0]        strap_rb_o
);
  logic       pg_sync_n;
  logic       locked_w;
  logic       test_w;
  logic       cap_a_w;
  logic       cap_b_w;
  logic       cap_evt_w;
  fsel_mode_e mode_w;

  fsel_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pgood_n),
    .q    (pg_sync_n)
  );

  fsel_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .pg_sync_n(pg_sync_n),
    .strap_a  (strap_a),
    .strap_b  (strap_b),
    .locked   (locked_w),
    .test_mode(test_w),
    .cap_a    (cap_a_w),
    .cap_b    (cap_b_w),
    .cap_evt  (cap_evt_w)
  );

  fsel_decode u_dec (
    .locked   (locked_w),
    .test_mode(test_w),
    .cap_a    (cap_a_w),
    .cap_b    (cap_b_w),
    .live_a   (strap_a),
    .boost    (boost_sel),
    .mode     (mode_w),
    .freq_idx (freq_idx_o)
  );

  assign mode_o     = mode_w;
  assign strap_rb_o = {cap_b_w, cap_a_w};
endmodule

// File: rtl/fsel_strap_ctrl_chk.sv
module fsel_strap_ctrl_chk
  import fsel_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pg_sync_n,
  input logic              locked,
  input logic              test_mode,
  input logic [MODE_W-1:0] mode_o,
  input logic [FIDX_W-1:0] freq_idx_o,
  input logic [1:0]        strap_rb_o
);
  // R1
  unlocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (mode_o == 2'd0 && freq_idx_o == 3'd7 && strap_rb_o == 2'b00));

  // R2
  cap_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> !$past(pg_sync_n));

  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R3
  rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(strap_rb_o));

  // R6
  test_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> test_mode);

  // R7
  test_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> (mode_o[1] && freq_idx_o == 3'd7));

  // R4
  run_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1) |-> (freq_idx_o <= 3'd4));
endmodule

bind fsel_strap_ctrl fsel_strap_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pg_sync_n (pg_sync_n),
  .locked    (locked_w),
  .test_mode (test_w),
  .mode_o    (mode_o),
  .freq_idx_o(freq_idx_o),
  .strap_rb_o(strap_rb_o)
);

// File: tb/fsel_strap_ctrl_bench.sv
`timescale 1ns/1ps
module fsel_strap_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pgood_n = 1'b1;
  logic       strap_a = 1'b0;
  logic [1:0] strap_b = 2'b00;
  logic       boost_sel = 1'b0;
  logic [1:0] mode_o;
  logic [2:0] freq_idx_o;
  logic [1:0] strap_rb_o;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [1:0] BL = 2'b00, BH = 2'b01, BM = 2'b10, BM2 = 2'b11;

  always #2.5 clk = ~clk;

  fsel_strap_ctrl u_fsel_strap_ctrl (
    .clk(clk), .rst_n(rst_n), .pgood_n(pgood_n), .strap_a(strap_a),
    .strap_b(strap_b), .boost_sel(boost_sel), .mode_o(mode_o),
    .freq_idx_o(freq_idx_o), .strap_rb_o(strap_rb_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Expected MHz-to-index mapping, written from the requirement table.
  function automatic int exp_idx(input bit a, input bit b, input bit boost);
    int mhz;
    if (a && !b)      mhz = boost ? 266 : 133;
    else if (!a && b) mhz = boost ? 400 : 200;
    else              mhz = boost ? 200 : 100;
    case (mhz)
      100: return 0;
      133: return 1;
      200: return 2;
      266: return 3;
      default: return 4;
    endcase
  endfunction

  task automatic do_reset(input logic [1:0] b);
    @(negedge clk);
    rst_n = 1'b0; pgood_n = 1'b1; strap_b = b; strap_a = 1'b0; boost_sel = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic capture(input bit a, input logic [1:0] b);
    @(negedge clk);
    strap_a = a; strap_b = b; pgood_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    do_reset(BL);
    repeat (3) @(posedge clk); #1;
    chk("R1 mode", mode_o, 0);
    chk("R1 freq", freq_idx_o, 7);
    chk("R1 readback", strap_rb_o, 0);
  endtask

  task automatic t_latency();
    do_reset(BL);
    @(negedge clk);
    strap_a = 1'b1; strap_b = BL; pgood_n = 1'b0;
    repeat (2) @(posedge clk); #1;
    chk("R2 not yet locked after 2 edges", mode_o, 0);
    @(posedge clk); #1;
    chk("R2 locked after 3rd edge", mode_o, 1);
    chk("R4 A1B0 133", freq_idx_o, 1);
  endtask

  task automatic t_decode();
    for (int k = 0; k < 4; k++) begin
      bit a = k[1];
      bit b = k[0];
      do_reset(BL);
      capture(a, b ? BH : BL);
      chk("R4 mode run", mode_o, 1);
      chk("R4 freq", freq_idx_o, exp_idx(a, b, 1'b0));
      chk("R8 readback", strap_rb_o, {b, a});
      @(negedge clk); boost_sel = 1'b1; #1;
      chk("R5 boost freq", freq_idx_o, exp_idx(a, b, 1'b1));
      @(negedge clk); boost_sel = 1'b0; #1;
      chk("R5 boost cleared", freq_idx_o, exp_idx(a, b, 1'b0));
    end
  endtask

  task automatic t_oneshot();
    do_reset(BL);
    capture(1'b0, BH);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      pgood_n = ~pgood_n; strap_a = ~strap_a; strap_b = (i % 2 == 0) ? BM : BL;
    end
    repeat (4) @(posedge clk); #1;
    chk("R3 mode kept", mode_o, 1);
    chk("R3 freq kept", freq_idx_o, 2);
    chk("R3 readback kept", strap_rb_o, 2'b10);
  endtask

  task automatic t_test();
    do_reset(BL);
    capture(1'b0, BM);
    chk("R6 enter test ref", mode_o, 2);
    chk("R7 freq none", freq_idx_o, 7);
    chk("R8 mid B reads 0", strap_rb_o, 0);
    @(negedge clk); #0.5 strap_a = 1'b1; #1;
    chk("R7 async A=1 hiz", mode_o, 3);
    #0.5 strap_a = 1'b0; #0.5;
    chk("R7 async A=0 ref", mode_o, 2);
    @(negedge clk); strap_b = BH; strap_a = 1'b1; pgood_n = 1'b1;
    repeat (5) @(posedge clk); #1;
    chk("R6 B ignored, still test", mode_o, 3);
    do_reset(BL);
    capture(1'b1, BM2);
    chk("R6 code 11 is mid", mode_o, 3);
    chk("R8 A readback in test", strap_rb_o, 2'b01);
  endtask

  task automatic t_exit();
    do_reset(BH);
    repeat (2) @(posedge clk); #1;
    chk("R9 reset leaves test", mode_o, 0);
    capture(1'b0, BH);
    chk("R9 normal after reset", mode_o, 1);
    chk("R9 freq", freq_idx_o, 2);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_decode();
    t_oneshot();
    t_test();
    t_exit();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule